// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of eight 16-bit words, each with its own valid flag. Software-side logic first loads a key register and a mask register. A search then compares the key against every word at once. Only the bit positions where the mask holds a 1 take part in the comparison, and only words whose valid flag is set can match. The per-word results are kept in a match register.

The hits are not returned together. Each read-next strobe moves one matching word, together with its index, into an output register, starting with the lowest index. That word's match bit is then cleared. A flag shows when no matches remain.

A write strobe stores the key register into the lowest-indexed free word and marks it valid. When every word is valid, a full flag is raised and writes are discarded. Room is made by invalidating a word by index. A synchronous clear empties the whole store.

Top module: `masked_cam`

## Requirements
- R1: After reset, no word is valid, the match register is empty (`no_match`=1), `out_valid`=0 and `full`=0.
- R2: On the edge after a `search` strobe, match bit i is 1 exactly when word i is valid and equals the key register on every bit position where the mask register is 1. `no_match` shows whether any bit is set.
- R3: Bit positions whose mask bit is 0 do not affect matching. A mask of all zeros matches every valid word.
- R4: A word whose valid flag is 0 never matches, whatever its stored bits.
- R5: Each `read_next` while matches remain loads `out_word` and `out_idx` with the lowest-indexed remaining match, sets `out_valid`=1, and clears that match bit, all on the next edge.
- R6: A `read_next` with an empty match register sets `out_valid` to 0 and leaves `no_match`=1.
- R7: A `write` stores the key register into the lowest-indexed invalid word and sets its valid flag.
- R8: `full` is 1 exactly when all words are valid. A `write` while full changes no word and no valid flag.
- R9: An `inval` clears the valid flag of word `inval_idx` and its match bit. A following write reuses that word.
- R10: A `clear` strobe clears every valid flag, the match register and `out_valid` on the next edge.
- R11: When `search` and `read_next` are strobed in the same cycle, the search wins. The match register is reloaded and the output register is left unchanged.
- R12: `key_load` and `mask_load` capture `key_in` and `mask_in` into the key and mask registers on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Capture `key_in` into the key register |
| key_in | input | 16 | Key value |
| mask_load | input | 1 | Capture `mask_in` into the mask register |
| mask_in | input | 16 | Compare mask, 1 = position compared |
| search | input | 1 | Compare all words and load the match register |
| read_next | input | 1 | Deliver the next match to the output register |
| write | input | 1 | Store the key register into a free word |
| clear | input | 1 | Synchronous clear of valid flags and matches |
| inval | input | 1 | Invalidate the word selected by `inval_idx` |
| inval_idx | input | 3 | Index of the word to invalidate |
| out_word | output | 16 | Delivered word |
| out_idx | output | 3 | Index of the delivered word |
| out_valid | output | 1 | Output register holds a delivered match |
| no_match | output | 1 | Match register is empty |
| full | output | 1 | Every word is valid |

## Verification
The bench attacks the readout order with sparse hit patterns such as indices 0, 2, 4 and 7. A design that delivered the highest hit first, or that did not clear the delivered bit, would repeat or skip words. Masked-off bits are made to differ from the key, which exposes a design that compares the full width. A write into a full store is followed by a search for the dropped value, which catches a design that overwrites a word. An invalidated word that still holds matching bits must vanish from searches and then be reused by the next write, which catches stale valid flags and a free-slot search that starts at the wrong end. A combined search and read strobe checks that the output register holds its value and that the reloaded matches come out in order.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  typedef struct packed {
    logic clr;
    logic search;
    logic rd;
    logic wr;
    logic inv;
  } cam_cmd_t;

  // a equals b on every position selected by m
  function automatic logic masked_eq(wide_t a, wide_t b, wide_t m);
    return ((a ^ b) & m) == '0;
  endfunction

  // index of the lowest set bit, 0 when none is set
  function automatic int unsigned first_one(wide_t v);
    int unsigned r;
    r = 0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (v[i]) r = unsigned'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  cam_cmd_t                    cmd,
  input  logic [WIDTH-1:0]            key_q,
  input  logic [IDXW-1:0]             inval_idx,
  output logic [WORDS-1:0][WIDTH-1:0] words,
  output logic [WORDS-1:0]            valid_q,
  output logic [WORDS-1:0]            kill_vec,
  output logic                        full
);

  logic [WORDS-1:0] free_vec;
  logic [IDXW-1:0]  wr_slot;
  logic             wr_fire;
  logic             inv_fire;

  assign free_vec = ~valid_q;
  assign full     = (free_vec == '0);
  assign wr_slot  = IDXW'(first_one(MAXW'(free_vec)));
  assign wr_fire  = cmd.wr && !full && !cmd.clr;
  assign inv_fire = cmd.inv && !cmd.clr;
  assign kill_vec = inv_fire ? (WORDS'(1) << inval_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      words   <= '0;
    end else if (cmd.clr) begin
      valid_q <= '0;
    end else begin
      if (inv_fire) valid_q[inval_idx] <= 1'b0;
      if (wr_fire) begin
        valid_q[wr_slot] <= 1'b1;
        words[wr_slot]   <= key_q;
      end
    end
  end

  // R8
  wr_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wr && full && !cmd.inv && !cmd.clr |=> $stable(valid_q) && $stable(words));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> valid_q == '0);

  // R7
  write_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !cmd.inv |=> $countones(valid_q) == $countones($past(valid_q)) + 1);

endmodule

// File: rtl/cam_match.sv
module cam_match
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  cam_cmd_t                    cmd,
  input  logic [WIDTH-1:0]            key_q,
  input  logic [WIDTH-1:0]            mask_q,
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [WORDS-1:0]            valid_q,
  input  logic [WORDS-1:0]            kill_vec,
  output logic [WIDTH-1:0]            out_word,
  output logic [IDXW-1:0]             out_idx,
  output logic                        out_valid,
  output logic                        none_left
);

  logic [WORDS-1:0] hit_vec;
  logic [WORDS-1:0] match_q;
  logic [WORDS-1:0] live;
  logic [WORDS-1:0] match_d;
  logic [IDXW-1:0]  pop_idx;
  logic             have;
  logic             srch_fire;
  logic             rd_fire;

  for (genvar i = 0; i < WORDS; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && !kill_vec[i] &&
                        masked_eq(MAXW'(words[i]), MAXW'(key_q), MAXW'(mask_q));
  end

  assign srch_fire = cmd.search && !cmd.clr;
  assign rd_fire   = cmd.rd && !cmd.search && !cmd.clr;
  assign live      = match_q & ~kill_vec;
  assign have      = (live != '0);
  assign pop_idx   = IDXW'(first_one(MAXW'(live)));
  assign none_left = (match_q == '0);

  always_comb begin
    match_d = live;
    if (srch_fire) match_d = hit_vec;
    else if (rd_fire && have) match_d[pop_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= '0;
      out_word  <= '0;
      out_idx   <= '0;
      out_valid <= 1'b0;
    end else if (cmd.clr) begin
      match_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      match_q <= match_d;
      if (rd_fire) begin
        out_valid <= have;
        if (have) begin
          out_word <= words[pop_idx];
          out_idx  <= pop_idx;
        end
      end
    end
  end

  // R5
  pop_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && have |=> out_valid && $countones(match_q) == $countones($past(live)) - 1);

  // R5
  pop_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && have |=> ($past(live) & ((WORDS'(1) << out_idx) - WORDS'(1))) == '0);

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && !have |=> !out_valid && none_left);

  // R11
  search_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_fire |=> $stable(out_valid) && $stable(out_idx) && $stable(out_word));

endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             mask_load,
  input  logic [WIDTH-1:0] mask_in,
  input  logic             search,
  input  logic             read_next,
  input  logic             write,
  input  logic             clear,
  input  logic             inval,
  input  logic [IDXW-1:0]  inval_idx,
  output logic [WIDTH-1:0] out_word,
  output logic [IDXW-1:0]  out_idx,
  output logic             out_valid,
  output logic             no_match,
  output logic             full
);

  cam_cmd_t                    cmd;
  logic [WIDTH-1:0]            key_q;
  logic [WIDTH-1:0]            mask_q;
  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WORDS-1:0]            valid_q;
  logic [WORDS-1:0]            kill_vec;

  assign cmd = '{clr: clear, search: search, rd: read_next, wr: write, inv: inval};

  // R12: key and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      mask_q <= '0;
    end else begin
      if (key_load)  key_q  <= key_in;
      if (mask_load) mask_q <= mask_in;
    end
  end

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .key_q(key_q), .inval_idx(inval_idx),
    .words(words), .valid_q(valid_q), .kill_vec(kill_vec), .full(full)
  );

  cam_match #(.WORDS(WORDS), .WIDTH(WIDTH), .IDXW(IDXW)) u_match (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .key_q(key_q), .mask_q(mask_q),
    .words(words), .valid_q(valid_q), .kill_vec(kill_vec),
    .out_word(out_word), .out_idx(out_idx), .out_valid(out_valid),
    .none_left(no_match)
  );

  // R12
  key_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> key_q == $past(key_in));

endmodule

// File: tb/test_masked_cam.sv
module test_masked_cam;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_load = 1'b0, mask_load = 1'b0;
  logic [15:0] key_in = '0, mask_in = '0;
  logic        search = 1'b0, read_next = 1'b0, write = 1'b0, clear = 1'b0, inval = 1'b0;
  logic [2:0]  inval_idx = '0;
  logic [15:0] out_word;
  logic [2:0]  out_idx;
  logic        out_valid, no_match, full;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] m_word [8];
  logic        m_val  [8];

  always #2.5 clk = ~clk;

  masked_cam i_masked_cam (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .mask_load(mask_load), .mask_in(mask_in), .search(search),
    .read_next(read_next), .write(write), .clear(clear), .inval(inval),
    .inval_idx(inval_idx), .out_word(out_word), .out_idx(out_idx),
    .out_valid(out_valid), .no_match(no_match), .full(full)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    key_load = 0; mask_load = 0; search = 0; read_next = 0;
    write = 0; clear = 0; inval = 0;
  endtask

  task automatic load_km(logic [15:0] k, logic [15:0] m);
    @(negedge clk);
    key_in = k; mask_in = m; key_load = 1; mask_load = 1;
    idle();
  endtask

  function automatic logic [7:0] expect_vec(logic [15:0] k, logic [15:0] m);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++)
      if (m_val[i] && ((m_word[i] & m) == (k & m))) v[i] = 1'b1;
    return v;
  endfunction

  task automatic do_search(string tag, logic [15:0] k, logic [15:0] m);
    load_km(k, m);
    @(negedge clk); search = 1;
    idle();
    chk({tag, " no_match after search"}, no_match, expect_vec(k, m) == '0);
  endtask

  task automatic do_read();
    @(negedge clk); read_next = 1;
    idle();
  endtask

  task automatic drain(string tag, logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      if (v[i]) begin
        do_read();
        chk({tag, " out_valid"}, out_valid, 1);
        chk({tag, " out_idx"}, out_idx, i);
        chk({tag, " out_word"}, out_word, m_word[i]);
      end
    end
    do_read();
    chk({tag, " R6 empty read out_valid"}, out_valid, 0);
    chk({tag, " R6 no_match"}, no_match, 1);
  endtask

  task automatic do_write(logic [15:0] v);
    bit placed;
    @(negedge clk); key_in = v; key_load = 1;
    idle();
    @(negedge clk); write = 1;
    idle();
    placed = 0;
    for (int i = 0; i < 8; i++)
      if (!placed && !m_val[i]) begin
        m_val[i] = 1; m_word[i] = v; placed = 1;
      end
  endtask

  task automatic t_reset();
    chk("R1 no_match", no_match, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 full", full, 0);
    do_search("R1", 16'h0000, 16'h0000);
  endtask

  task automatic t_fill();
    logic [15:0] vals [8] = '{16'hA0A0, 16'h1234, 16'hA5FF, 16'h0F0F,
                              16'hA0B1, 16'hFFFF, 16'h0000, 16'hA0A0};
    for (int i = 0; i < 8; i++) begin
      do_write(vals[i]);
      chk("R8 full while filling", full, i == 7);
    end
    do_search("R7 placement", 16'h0000, 16'h0000);
    drain("R7 placement", expect_vec(16'h0000, 16'h0000));
  endtask

  task automatic t_search_hi();
    do_search("R2", 16'hA000, 16'hF000);
    drain("R2 R5 high nibble", expect_vec(16'hA000, 16'hF000));
  endtask

  task automatic t_mask();
    do_search("R3 exact", 16'h1234, 16'hFFFF);
    drain("R3 exact", expect_vec(16'h1234, 16'hFFFF));
    do_search("R3 ignored low byte", 16'h12EE, 16'hFF00);
    drain("R3 ignored low byte", expect_vec(16'h12EE, 16'hFF00));
  endtask

  task automatic t_full_drop();
    do_write(16'h5555);
    chk("R8 full stays", full, 1);
    do_search("R8 dropped", 16'h5555, 16'hFFFF);
    do_read();
    chk("R8 dropped word absent", out_valid, 0);
  endtask

  task automatic t_inval();
    @(negedge clk); inval_idx = 3'd2; inval = 1;
    idle();
    m_val[2] = 0;
    chk("R9 full after inval", full, 0);
    do_search("R4", 16'hA000, 16'hF000);
    drain("R4 invalid never matches", expect_vec(16'hA000, 16'hF000));
    do_write(16'h5555);
    do_search("R9 reuse", 16'h5555, 16'hFFFF);
    do_read();
    chk("R9 reuse index", out_idx, 2);
    chk("R9 reuse word", out_word, 16'h5555);
  endtask

  task automatic t_priority();
    do_search("R11 setup", 16'h0000, 16'h0000);
    do_read();
    do_read();
    chk("R11 setup idx", out_idx, 1);
    load_km(16'hA0A0, 16'hFFFF);
    @(negedge clk); search = 1; read_next = 1;
    idle();
    chk("R11 out_idx held", out_idx, 1);
    chk("R11 out_valid held", out_valid, 1);
    drain("R11 reloaded", expect_vec(16'hA0A0, 16'hFFFF));
  endtask

  task automatic t_clear();
    do_search("R10 setup", 16'h0000, 16'h0000);
    do_read();
    @(negedge clk); clear = 1;
    idle();
    for (int i = 0; i < 8; i++) m_val[i] = 0;
    chk("R10 no_match", no_match, 1);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 full", full, 0);
    do_search("R10 empty", 16'h0000, 16'h0000);
    do_write(16'h7777);
    do_search("R10 refill", 16'h0000, 16'h0000);
    do_read();
    chk("R10 refill idx", out_idx, 0);
    chk("R12 key capture", out_word, 16'h7777);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_word[i] = '0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_search_hi();
    t_mask();
    t_full_drop();
    t_inval();
    t_priority();
    t_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #200us;
    join_any
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule